// File: doc/BRIEF.md
# DMA Request Size Checker and Packetizer

This block sits between a DMA request source and a 16-byte-wide transport. It takes one request at a time, made of a start address and a byte count. It decides whether the size and the alignment are allowed. A legal request is broken into beats of 16 bytes. The beats are grouped into bus packets of up to eight beats, which is 128 bytes. An illegal request produces a one-cycle error pulse and sends nothing downstream.

Both sides use a valid/ready handshake. Each beat carries an address, a byte-enable mask, an end-of-packet marker and an end-of-request marker. Small transfers of 1, 2, 4 or 8 bytes fit in a single beat. For these, the byte enables select only the lanes the transfer touches. Transfers that are a multiple of 16 bytes run over full-width beats, with the address stepping by 16 on each beat.

Top module: `dma_pktz`

## Requirements
- R1: Out of reset, req_ready_o is 1, pkt_valid_o is 0 and err_o is 0.
- R2: The legal sizes are 1, 2, 4 and 8 bytes, and any nonzero multiple of 16 up to 16384 bytes. Any other size is rejected, including 0, non-power-of-two values below 16, values that are not a multiple of 16 above 16, and sizes above 16384.
- R3: A size below 16 needs the start address to be a multiple of the size. A multiple-of-16 size needs address bits [3:0] to be zero. A request that breaks either rule is rejected.
- R4: A legal size below 16 gives exactly one beat. That beat has pkt_addr_o equal to the request address. In pkt_be_o, bit b is set exactly when addr[3:0] <= b < addr[3:0]+size. The beat has pkt_eop_o=1 and pkt_last_o=1.
- R5: A legal multiple-of-16 size gives size/16 beats. Beat k has address start+16*k and pkt_be_o=16'hFFFF.
- R6: On beat k of N, pkt_eop_o is 1 exactly when k mod 8 = 7 or k = N-1. pkt_last_o is 1 only when k = N-1.
- R7: While pkt_valid_o=1 and pkt_ready_i=0, the beat outputs hold steady. req_ready_o is 0 from the cycle after a legal request is accepted until the cycle after its final beat is taken.
- R8: A rejected request, once accepted, raises err_o for exactly the following cycle. It emits no beat, and req_ready_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | ADDR_W (32) | Start byte address |
| req_len_i | input | LEN_W (15) | Byte count |
| err_o | output | 1 | One-cycle pulse for a rejected request |
| pkt_valid_o | output | 1 | Beat valid |
| pkt_ready_i | input | 1 | Downstream takes the beat |
| pkt_addr_o | output | ADDR_W (32) | Beat address |
| pkt_be_o | output | BEAT_BYTES (16) | Byte-lane enables |
| pkt_eop_o | output | 1 | Last beat of a 128-byte packet |
| pkt_last_o | output | 1 | Last beat of the request |

## Verification
The hardest cases to reach are the packet boundaries inside long transfers, together with back-pressure that lands on them. Only requests longer than 128 bytes cross a packet edge. The full 16384-byte case runs 1024 beats and crosses 127 boundaries. The stimulus sweeps every size from 0 to 320 at all sixteen address offsets. It then sends the maximum size and the sizes on either side of it. Throughout, pkt_ready_i is dropped on a pattern that shifts with the beat index, so stalls fall on eop beats and on last beats as well as on ordinary ones.

// File: rtl/dma_pktz_pkg.sv
package dma_pktz_pkg;
  parameter int unsigned BEAT_BYTES = 16;
  parameter int unsigned PKT_BEATS  = 8;
  parameter int unsigned MAX_BYTES  = 16384;

  typedef enum logic [1:0] {
    KIND_BAD   = 2'd0,
    KIND_SMALL = 2'd1,
    KIND_BULK  = 2'd2
  } req_kind_e;
endpackage

// File: rtl/dma_size_chk.sv
module dma_size_chk
  import dma_pktz_pkg::*;
#(
  parameter int unsigned LEN_W      = 15,
  parameter int unsigned BEAT_BYTES = 16,
  parameter int unsigned MAX_BYTES  = 16384,
  localparam int unsigned OFF_W     = $clog2(BEAT_BYTES)
) (
  input  logic [OFF_W-1:0]      off_i,
  input  logic [LEN_W-1:0]      len_i,
  output req_kind_e             kind_o,
  output logic [BEAT_BYTES-1:0] be_o
);
  logic             small_sz, small_ok, bulk_ok;
  logic [OFF_W-1:0] len_lo;

  assign len_lo   = len_i[OFF_W-1:0];
  assign small_sz = (len_i != '0) && (len_i < LEN_W'(BEAT_BYTES)) &&
                    ((len_i & (len_i - 1'b1)) == '0);
  // power-of-two size: misaligned iff any offset bit below the size is set
  assign small_ok = small_sz && ((off_i & (len_lo - 1'b1)) == '0);
  assign bulk_ok  = (len_i != '0) && (len_lo == '0) &&
                    (len_i <= LEN_W'(MAX_BYTES)) && (off_i == '0);

  always_comb begin
    if (bulk_ok)       kind_o = KIND_BULK;
    else if (small_ok) kind_o = KIND_SMALL;
    else               kind_o = KIND_BAD;
  end

  always_comb begin
    be_o = '0;
    for (int b = 0; b < BEAT_BYTES; b++) begin
      if (bulk_ok) be_o[b] = 1'b1;
      else if ((b >= int'(off_i)) && (b < int'(off_i) + int'(len_i))) be_o[b] = 1'b1;
    end
  end
endmodule

// File: rtl/dma_beat_gen.sv
module dma_beat_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned BEAT_BYTES = 16,
  parameter int unsigned PKT_BEATS  = 8,
  localparam int unsigned IDX_W     = (PKT_BEATS > 1) ? $clog2(PKT_BEATS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CNT_W-1:0]      nbeats_i,
  input  logic [BEAT_BYTES-1:0] be_i,
  output logic                  busy_o,
  output logic                  pkt_valid_o,
  input  logic                  pkt_ready_i,
  output logic [ADDR_W-1:0]     pkt_addr_o,
  output logic [BEAT_BYTES-1:0] pkt_be_o,
  output logic                  pkt_eop_o,
  output logic                  pkt_last_o
);
  logic                  busy_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [CNT_W-1:0]      left_q;
  logic [IDX_W-1:0]      idx_q;
  logic [BEAT_BYTES-1:0] be_q;
  logic                  pop, last;

  assign last = (left_q == CNT_W'(1));
  assign pop  = busy_q && pkt_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      idx_q  <= '0;
      be_q   <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      addr_q <= addr_i;
      left_q <= nbeats_i;
      idx_q  <= '0;
      be_q   <= be_i;
    end else if (pop) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        addr_q <= addr_q + ADDR_W'(BEAT_BYTES);
        left_q <= left_q - 1'b1;
        idx_q  <= (idx_q == IDX_W'(PKT_BEATS - 1)) ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign busy_o      = busy_q;
  assign pkt_valid_o = busy_q;
  assign pkt_addr_o  = addr_q;
  assign pkt_be_o    = be_q;
  assign pkt_last_o  = last;
  assign pkt_eop_o   = last || (idx_q == IDX_W'(PKT_BEATS - 1));

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_addr_o) && $stable(pkt_be_o)
      && $stable(pkt_eop_o) && $stable(pkt_last_o)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && pkt_ready_i && !pkt_last_o |=>
      pkt_valid_o && (pkt_addr_o == $past(pkt_addr_o) + ADDR_W'(BEAT_BYTES))); // R5
endmodule

// File: rtl/dma_pktz.sv
module dma_pktz
  import dma_pktz_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BEAT_BYTES = dma_pktz_pkg::BEAT_BYTES,
  parameter int unsigned PKT_BEATS  = dma_pktz_pkg::PKT_BEATS,
  parameter int unsigned MAX_BYTES  = dma_pktz_pkg::MAX_BYTES,
  localparam int unsigned LEN_W     = $clog2(MAX_BYTES) + 1,
  localparam int unsigned OFF_W     = $clog2(BEAT_BYTES),
  localparam int unsigned CNT_W     = LEN_W - OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [LEN_W-1:0]      req_len_i,
  output logic                  err_o,
  output logic                  pkt_valid_o,
  input  logic                  pkt_ready_i,
  output logic [ADDR_W-1:0]     pkt_addr_o,
  output logic [BEAT_BYTES-1:0] pkt_be_o,
  output logic                  pkt_eop_o,
  output logic                  pkt_last_o
);
  req_kind_e             kind;
  logic [BEAT_BYTES-1:0] be;
  logic [CNT_W-1:0]      nbeats;
  logic                  busy, accept, load, err_q;

  dma_size_chk #(
    .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES), .MAX_BYTES(MAX_BYTES)
  ) u_chk (
    .off_i (req_addr_i[OFF_W-1:0]),
    .len_i (req_len_i),
    .kind_o(kind),
    .be_o  (be)
  );

  assign accept = req_valid_i && req_ready_o;
  assign load   = accept && (kind != KIND_BAD);
  assign nbeats = (kind == KIND_BULK) ? req_len_i[LEN_W-1:OFF_W] : CNT_W'(1);

  dma_beat_gen #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES), .PKT_BEATS(PKT_BEATS)
  ) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .addr_i     (req_addr_i),
    .nbeats_i   (nbeats),
    .be_i       (be),
    .busy_o     (busy),
    .pkt_valid_o(pkt_valid_o),
    .pkt_ready_i(pkt_ready_i),
    .pkt_addr_o (pkt_addr_o),
    .pkt_be_o   (pkt_be_o),
    .pkt_eop_o  (pkt_eop_o),
    .pkt_last_o (pkt_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= accept && (kind == KIND_BAD);
  end

  assign err_o       = err_q;
  assign req_ready_o = !busy;

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i && req_ready_o)); // R8
  AST_NO_PKT_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !pkt_valid_o && req_ready_o); // R8
  AST_BE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (pkt_be_o != '0)); // R4
  AST_BUSY_UNTIL_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !(pkt_ready_i && pkt_last_o) |=> pkt_valid_o && !req_ready_o); // R7
endmodule

// File: tb/dma_pktz_bench.sv
module dma_pktz_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 15;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [LEN_W-1:0]  req_len_i = '0;
  logic              err_o;
  logic              pkt_valid_o;
  logic              pkt_ready_i = 1'b0;
  logic [ADDR_W-1:0] pkt_addr_o;
  logic [15:0]       pkt_be_o;
  logic              pkt_eop_o;
  logic              pkt_last_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_pktz u_dma_pktz (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_len_i,
    .err_o, .pkt_valid_o, .pkt_ready_i, .pkt_addr_o, .pkt_be_o, .pkt_eop_o, .pkt_last_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h len=%0d addr=%0h", req, act, exp, req_len_i, req_addr_i);
    end
  endtask

  task automatic run_req(input logic [ADDR_W-1:0] addr, input int len);
    bit small_legal, bulk_legal;
    int n, off;
    logic [15:0] exp_be;
    off = int'(addr[3:0]);
    small_legal = (len == 1 || len == 2 || len == 4 || len == 8) && (off % len == 0);
    bulk_legal  = (len > 0) && (len % 16 == 0) && (len <= 16384) && (off == 0);
    chk(req_ready_o == 1'b1, "R7 ready idle", longint'(req_ready_o), 1);
    req_valid_i = 1'b1; req_addr_i = addr; req_len_i = LEN_W'(len);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (!(small_legal || bulk_legal)) begin
      chk(err_o == 1'b1, "R2 R3 R8 err pulse", longint'(err_o), 1);
      chk(pkt_valid_o == 1'b0 && req_ready_o == 1'b1, "R8 no beat",
          longint'({pkt_valid_o, req_ready_o}), 1);
      @(negedge clk_i);
      chk(err_o == 1'b0 && pkt_valid_o == 1'b0, "R8 pulse ends",
          longint'({err_o, pkt_valid_o}), 0);
      return;
    end
    chk(err_o == 1'b0, "R2 R3 legal no err", longint'(err_o), 0);
    n = small_legal ? 1 : len / 16;
    exp_be = '0;
    for (int b = 0; b < 16; b++) if (bulk_legal || (b >= off && b < off + len)) exp_be[b] = 1'b1;
    for (int k = 0; k < n; k++) begin
      logic [ADDR_W-1:0] ea;
      bit ee, el, stall;
      ea = small_legal ? addr : addr + ADDR_W'(16 * k);
      ee = (k % 8 == 7) || (k == n - 1);
      el = (k == n - 1);
      stall = ((k * 7 + len) % 5) == 0;
      if (stall) begin
        pkt_ready_i = 1'b0;
        @(negedge clk_i);
        @(negedge clk_i);
      end
      chk(pkt_valid_o && !req_ready_o, "R7 busy", longint'({pkt_valid_o, req_ready_o}), 2);
      chk(pkt_addr_o == ea, small_legal ? "R4 addr" : "R5 addr", longint'(pkt_addr_o), longint'(ea));
      chk(pkt_be_o == exp_be, small_legal ? "R4 be" : "R5 be", longint'(pkt_be_o), longint'(exp_be));
      chk(pkt_eop_o == ee && pkt_last_o == el, "R6 eop last",
          longint'({pkt_eop_o, pkt_last_o}), longint'({ee, el}));
      pkt_ready_i = 1'b1;
      @(negedge clk_i);
    end
    pkt_ready_i = 1'b0;
    chk(!pkt_valid_o && req_ready_o, "R5 R7 done after final beat",
        longint'({pkt_valid_o, req_ready_o}), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    bad++; total++;
    $display("FAIL watchdog expired R7 act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    chk(req_ready_o == 1 && pkt_valid_o == 0 && err_o == 0, "R1 in reset",
        longint'({req_ready_o, pkt_valid_o, err_o}), 4);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1 && pkt_valid_o == 0 && err_o == 0, "R1 after reset",
        longint'({req_ready_o, pkt_valid_o, err_o}), 4);
    for (int len = 0; len <= 320; len++)
      for (int off = 0; off < 16; off++)
        run_req(32'h1000_0000 + 32'(len * 64) + 32'(off), len);
    run_req(32'h2000_0000, 16384);
    run_req(32'h3000_0000, 16400);
    run_req(32'h3000_0000, 16368);
    run_req(32'h3000_0004, 16384);
    run_req(32'h0000_0007, 0);
    run_req(32'h4000_000C, 4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule